// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a system watchdog. Software configures it through four 32-bit word registers on a simple valid/write/address/data port. The four registers are mode, counter control, restart and status. Once the watchdog is enabled, a down-counter is loaded from a 12-bit reload value. It then decrements once per tick of a selectable clock prescaler. If software fails to restart it in time, the counter reaches zero and the block latches a timeout flag. When the matching output is enabled, the block also emits a reset pulse and an interrupt pulse, and the length of each pulse is programmable.

Stray or corrupted bus traffic must not be able to reconfigure or feed the watchdog. For this reason, a mode or counter-control write is accepted only when a fixed access key is embedded in that write. A restart is accepted only when the exact restart word is written. Every other write leaves the block untouched.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, mode reads 0x0000_0000, counter control reads 0x0000_3FFC (reload 0xFFF, prescaler code 0), restart and status read 0, and both pulse outputs are low.
- R2: A write to offset 0x0 is accepted only if bits 23:12 hold 0xABC. An accepted write sets enable (bit0), reset-output enable (bit1), interrupt-output enable (bit2), reset length code (bits 6:4) and interrupt length code (bits 8:7). A write with any other key changes nothing.
- R3: A write to offset 0x4 is accepted only if bits 25:14 hold 0x248. An accepted write sets the prescaler code (bits 1:0) and the reload value (bits 13:2). A write with any other key changes nothing.
- R4: A read returns its data one clock after the request and holds it until the next read. Key fields read as zero, offset 0x8 reads zero, and offset 0xC returns the timeout flag in bit0.
- R5: Prescaler codes 0, 1, 2 and 3 give one tick every 8, 64, 512 and 4096 clocks. After an enabling write, the first tick comes one full period later.
- R6: A reload loads the counter with the reload value in the upper bits and all ones in the low fill bits. The counter moves only on ticks while enabled. Clearing enable freezes the counter and clears the prescaler.
- R7: Writing exactly 0x0000_1999 to offset 0x8 reloads the counter, restarts the prescaler and clears the timeout flag. Any other value is ignored.
- R8: On the tick that takes the counter from 1 to 0, the timeout flag sets. The counter then holds at zero. The flag stays set until a valid restart, or until an accepted mode write sets enable while enable was clear (this also reloads).
- R9: If reset output is enabled at timeout, the reset pulse is high for 2^(code+1) prescaler ticks, counted from the timeout tick.
- R10: If interrupt output is enabled at timeout, the interrupt pulse is high for 4 << code clock cycles.
- R11: With both output enables clear, a timeout sets the status flag but leaves both pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_rst_o | output | 1 | Reset pulse |
| wdt_irq_o | output | 1 | Interrupt pulse |

## Verification
Several properties are checked on every clock edge:
- A write carrying a wrong key leaves the stored mode or counter-control fields unchanged.
- The counter never rises except through a reload.
- A disabled prescaler is held at zero.
- A set timeout flag implies a zero count.
- Each pulse starts only after a trigger.

Other behaviour shows only in the bench's scenarios, against a cycle-accurate behavioural model: the actual tick periods of each prescaler code, the exact pulse widths, the restart-word and re-enable rules that clear the timeout, and the absence of pulses when the outputs are disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W   = 32;
  localparam int RELOAD_W = 12;
  localparam int SEL_W    = 2;
  localparam int KEY_W    = 12;
  localparam int MODE_KEY_LSB = 12;
  localparam int CTRL_KEY_LSB = 14;
  localparam int RELOAD_LSB   = 2;

  localparam logic [3:0] OFS_MODE = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_KICK = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;

  localparam logic [KEY_W-1:0]  MODE_KEY  = 12'hABC;
  localparam logic [KEY_W-1:0]  CTRL_KEY  = 12'h248;
  localparam logic [DATA_W-1:0] KICK_WORD = 32'h0000_1999;

  typedef struct packed {
    logic       run;
    logic       rst_en;
    logic       irq_en;
    logic [2:0] rst_len;
    logic [1:0] irq_len;
  } mode_t;

  typedef struct packed {
    logic [RELOAD_W-1:0] reload;
    logic [SEL_W-1:0]    sel;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              timeout_i,
  output mode_t             mode_o,
  output ctrl_t             ctrl_o,
  output logic              reload_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr, rd;
  logic hit_mode, hit_ctrl, hit_kick, hit_stat;
  logic mode_ok, ctrl_ok, kick_ok;
  mode_t mode_q;
  ctrl_t ctrl_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  always_comb begin
    wr       = req_valid & req_write;
    rd       = req_valid & ~req_write;
    hit_mode = (req_addr == ADDR_W'(OFS_MODE));
    hit_ctrl = (req_addr == ADDR_W'(OFS_CTRL));
    hit_kick = (req_addr == ADDR_W'(OFS_KICK));
    hit_stat = (req_addr == ADDR_W'(OFS_STAT));
    mode_ok  = wr & hit_mode & (req_wdata[MODE_KEY_LSB +: KEY_W] == MODE_KEY);
    ctrl_ok  = wr & hit_ctrl & (req_wdata[CTRL_KEY_LSB +: KEY_W] == CTRL_KEY);
    kick_ok  = wr & hit_kick & (req_wdata == KICK_WORD);
  end

  // restart word, or enable set while it was clear
  assign reload_o = kick_ok | (mode_ok & req_wdata[0] & ~mode_q.run);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ctrl_q <= '{reload: '1, sel: '0};
    end else begin
      if (mode_ok) begin
        mode_q <= '{run:     req_wdata[0],
                    rst_en:  req_wdata[1],
                    irq_en:  req_wdata[2],
                    rst_len: req_wdata[6:4],
                    irq_len: req_wdata[8:7]};
      end
      if (ctrl_ok) begin
        ctrl_q <= '{reload: req_wdata[RELOAD_LSB +: RELOAD_W],
                    sel:    req_wdata[SEL_W-1:0]};
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_mode) begin
      rd_mux = {23'b0, mode_q.irq_len, mode_q.rst_len, 1'b0,
                mode_q.irq_en, mode_q.rst_en, mode_q.run};
    end else if (hit_ctrl) begin
      rd_mux = {{(DATA_W-RELOAD_W-SEL_W){1'b0}}, ctrl_q.reload, ctrl_q.sel};
    end else if (hit_stat) begin
      rd_mux = {{(DATA_W-1){1'b0}}, timeout_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign mode_o  = mode_q;
  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;

  // R2
  mode_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_mode && req_wdata[MODE_KEY_LSB +: KEY_W] != MODE_KEY) |=> $stable(mode_q));

  // R3
  ctrl_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_ctrl && req_wdata[CTRL_KEY_LSB +: KEY_W] != CTRL_KEY) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 3,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CODES = 1 << SEL_W;
  localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * (CODES - 1);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limits [CODES];
  logic [PRE_W-1:0] limit;

  for (genvar g = 0; g < CODES; g++) begin : g_lim
    assign limits[g] = PRE_W'((64'd1 << (BASE_LOG2 + STEP_LOG2 * g)) - 64'd1);
  end

  assign limit  = limits[sel_i];
  assign tick_o = run_i & (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run_i || clr_i || tick_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + PRE_W'(1);
  end

  // R6
  presc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int RELOAD_W = 12,
  parameter int FILL_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                reload_i,
  input  logic [RELOAD_W-1:0] reload_val_i,
  output logic                expire_o,
  output logic                timeout_o
);
  localparam int CNT_W = RELOAD_W + FILL_W;

  logic [CNT_W-1:0] cnt_q;
  logic             timeout_q;

  assign expire_o = tick_i & ~reload_i & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '1;
      timeout_q <= 1'b0;
    end else begin
      if (reload_i)                   cnt_q <= {reload_val_i, {FILL_W{1'b1}}};
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      if (reload_i)      timeout_q <= 1'b0;
      else if (expire_o) timeout_q <= 1'b1;
    end
  end

  assign timeout_o = timeout_q;

  // R8
  timeout_zero_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_q |-> (cnt_q == '0));

  // R6
  no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic             pulse_o
);
  logic             pulse_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (trig_i) begin
      pulse_q <= 1'b1;
      left_q  <= len_m1_i;
    end else if (pulse_q && step_i) begin
      if (left_q == '0) pulse_q <= 1'b0;
      else              left_q  <= left_q - LEN_W'(1);
    end
  end

  assign pulse_o = pulse_q;

  // R9 R10
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> $past(trig_i));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FILL_W    = 12,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  localparam int PULSE_W = 8;

  mode_t mode;
  ctrl_t ctrl;
  logic  reload, tick, expire, timeout;
  logic [PULSE_W-1:0] rst_len_m1, irq_len_m1;

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(bus_valid), .req_write(bus_write),
    .req_addr(bus_addr), .req_wdata(bus_wdata),
    .timeout_i(timeout),
    .mode_o(mode), .ctrl_o(ctrl),
    .reload_o(reload), .rdata_o(bus_rdata)
  );

  wdt_prescaler #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst(rst),
    .run_i(mode.run), .clr_i(reload), .sel_i(ctrl.sel),
    .tick_o(tick)
  );

  wdt_countdown #(.RELOAD_W(RELOAD_W), .FILL_W(FILL_W)) u_count (
    .clk(clk), .rst(rst),
    .tick_i(tick), .reload_i(reload), .reload_val_i(ctrl.reload),
    .expire_o(expire), .timeout_o(timeout)
  );

  // reset pulse: 2^(code+1) ticks; interrupt pulse: 4 << code clocks
  assign rst_len_m1 = PULSE_W'((9'd2 << mode.rst_len) - 9'd1);
  assign irq_len_m1 = PULSE_W'((8'd4 << mode.irq_len) - 8'd1);

  wdt_pulse #(.LEN_W(PULSE_W)) u_rst_pulse (
    .clk(clk), .rst(rst),
    .trig_i(expire & mode.rst_en), .step_i(tick),
    .len_m1_i(rst_len_m1), .pulse_o(wdt_rst_o)
  );

  wdt_pulse #(.LEN_W(PULSE_W)) u_irq_pulse (
    .clk(clk), .rst(rst),
    .trig_i(expire & mode.irq_en), .step_i(1'b1),
    .len_m1_i(irq_len_m1), .pulse_o(wdt_irq_o)
  );
endmodule

// File: tb/test_wdt_keyed_top.sv
module test_wdt_keyed_top;
  localparam int FILL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0, write = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rst_o, irq_o;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  wdt_keyed_top #(.FILL_W(FILL)) i_wdt_keyed_top (
    .clk(clk), .rst(rst), .bus_valid(valid), .bus_write(write),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .wdt_rst_o(rst_o), .wdt_irq_o(irq_o)
  );

  // behavioural reference model
  bit m_en, m_re, m_ie, m_to, m_ron, m_ion;
  int m_rl, m_il, m_sel, m_reload, m_cnt, m_pre, m_rc, m_ic;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_re = 0; m_ie = 0; m_rl = 0; m_il = 0;
      m_sel = 0; m_reload = 'hFFF; m_cnt = ('hFFF << FILL) + (1 << FILL) - 1;
      m_pre = 0; m_to = 0; m_ron = 0; m_rc = 0; m_ion = 0; m_ic = 0; m_rd = 0;
    end else begin
      bit wr, mkey, ckey, rel, tick, expi;
      int dv;
      wr   = valid && write;
      mkey = (wdata[23:12] == 12'hABC);
      ckey = (wdata[25:14] == 12'h248);
      rel  = wr && ((addr == 4'h8 && wdata == 32'h1999) ||
                    (addr == 4'h0 && mkey && wdata[0] && !m_en));
      dv   = 8 << (3 * m_sel);
      tick = m_en && (m_pre >= dv - 1);
      expi = tick && !rel && (m_cnt == 1);
      if (expi && m_ie) begin m_ion = 1; m_ic = (4 << m_il) - 1; end
      else if (m_ion) begin if (m_ic == 0) m_ion = 0; else m_ic--; end
      if (expi && m_re) begin m_ron = 1; m_rc = (2 << m_rl) - 1; end
      else if (m_ron && tick) begin if (m_rc == 0) m_ron = 0; else m_rc--; end
      if (rel) m_cnt = (m_reload << FILL) + (1 << FILL) - 1;
      else if (tick && m_cnt != 0) m_cnt--;
      if (rel) m_to = 0; else if (expi) m_to = 1;
      if (rel || !m_en || tick) m_pre = 0; else m_pre++;
      if (valid && !write) begin
        case (addr)
          4'h0: m_rd = 32'((m_il << 7) | (m_rl << 4) | (m_ie << 2) | (m_re << 1) | m_en);
          4'h4: m_rd = 32'((m_reload << 2) | m_sel);
          4'hC: m_rd = 32'(m_to);
          default: m_rd = 0;
        endcase
      end
      if (wr && addr == 4'h0 && mkey) begin
        m_en = wdata[0]; m_re = wdata[1]; m_ie = wdata[2];
        m_rl = int'(wdata[6:4]); m_il = int'(wdata[8:7]);
      end
      if (wr && addr == 4'h4 && ckey) begin
        m_sel = int'(wdata[1:0]); m_reload = int'(wdata[13:2]);
      end
    end
  end

  // every-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (!rst) begin
      checks += 3;
      if (rdata !== m_rd) begin
        errors++; $display("FAIL R4 rdata act=%h exp=%h", rdata, m_rd);
      end
      if (rst_o !== m_ron) begin
        errors++; $display("FAIL R9 wdt_rst_o act=%b exp=%b", rst_o, m_ron);
      end
      if (irq_o !== m_ion) begin
        errors++; $display("FAIL R10 wdt_irq_o act=%b exp=%b", irq_o, m_ion);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; write = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; write = 0; addr = a;
    @(negedge clk); valid = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] mode_w(input bit en, re, ie, input int rl, il);
    return 32'h00AB_C000 | 32'(il << 7) | 32'(rl << 4) | 32'(ie << 2) | 32'(re << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] ctrl_w(input int rv, input int sel);
    return 32'h0092_0000 | 32'(rv << 2) | 32'(sel);
  endfunction

  // cycles from the enabling write until the reset pulse rises
  task automatic time_to_reset(output int n);
    n = 0;
    while (!rst_o && n < 20000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [31:0] d;
    int n, ni, nr;
    bit seen;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    bus_rd(4'h0, d); check("R1 mode reset", d, 32'h0);
    bus_rd(4'h4, d); check("R1 ctrl reset", d, 32'h3FFC);
    bus_rd(4'h8, d); check("R1 restart reads zero", d, 32'h0);
    bus_rd(4'hC, d); check("R1 status reset", d, 32'h0);
    check("R1 outputs low", {30'b0, rst_o, irq_o}, 32'h0);

    // R2 mode key
    bus_wr(4'h0, 32'h00AB_B007); bus_rd(4'h0, d); check("R2 bad key ignored", d, 32'h0);
    bus_wr(4'h0, mode_w(0, 1, 1, 5, 2)); bus_rd(4'h0, d);
    check("R2 R4 fields stored, key reads zero", d, 32'h156);

    // R3 counter-control key
    bus_wr(4'h4, 32'h0096_0009); bus_rd(4'h4, d); check("R3 bad key ignored", d, 32'h3FFC);
    bus_wr(4'h4, ctrl_w(2, 0)); bus_rd(4'h4, d); check("R3 fields stored", d, 32'h8);

    // R8 R9 R10: reload 2 -> count 11, 8 clocks per tick -> 88 clocks
    bus_wr(4'h0, mode_w(1, 1, 1, 0, 0));
    n = 0;
    while (!irq_o && n < 200) begin @(negedge clk); n++; end
    check("R8 timeout after 88 clocks", n, 88);
    ni = 0; nr = 0;
    for (int k = 0; k < 40; k++) begin
      if (irq_o) ni++;
      if (rst_o) nr++;
      @(negedge clk);
    end
    check("R10 irq pulse 4 clocks", ni, 4);
    check("R9 reset pulse 2 ticks", nr, 16);
    bus_rd(4'hC, d); check("R8 status set", d, 32'h1);
    idle(100);
    bus_rd(4'hC, d); check("R8 status held", d, 32'h1);

    // R7 restart word; R8 enable write while enabled does not reload
    bus_wr(4'h8, 32'h1998); bus_rd(4'hC, d); check("R7 wrong word ignored", d, 32'h1);
    bus_wr(4'h0, mode_w(1, 1, 1, 0, 0)); bus_rd(4'hC, d);
    check("R8 enable while enabled keeps flag", d, 32'h1);
    bus_wr(4'h8, 32'h1999); bus_rd(4'hC, d); check("R7 restart clears", d, 32'h0);
    for (int k = 0; k < 5; k++) begin
      idle(60);
      bus_wr(4'h8, 32'h1999);
      bus_rd(4'hC, d); check("R7 kept alive", d, 32'h0);
    end
    idle(120);
    bus_rd(4'hC, d); check("R8 timeout without restart", d, 32'h1);
    idle(40);

    // R6 disable freezes; R8 re-enable clears
    bus_wr(4'h0, mode_w(0, 1, 1, 0, 0));
    bus_wr(4'h0, mode_w(1, 1, 1, 0, 0));
    bus_rd(4'hC, d); check("R8 re-enable clears", d, 32'h0);
    idle(40);
    bus_wr(4'h0, mode_w(0, 1, 1, 0, 0));
    idle(300);
    bus_rd(4'hC, d); check("R6 frozen while disabled", d, 32'h0);
    bus_wr(4'h0, mode_w(1, 1, 1, 0, 0));
    idle(78);
    bus_rd(4'hC, d); check("R6 reloaded count not yet zero", d, 32'h0);
    idle(20);
    bus_rd(4'hC, d); check("R6 count expires after reload", d, 32'h1);
    idle(40);

    // R5 prescaler codes, reload 0 -> count 3
    bus_wr(4'h0, mode_w(0, 1, 0, 0, 0));
    bus_wr(4'h4, ctrl_w(0, 1));
    bus_wr(4'h0, mode_w(1, 1, 0, 0, 0));
    time_to_reset(n); check("R5 code1 divides by 64", n, 192);
    idle(200);
    bus_wr(4'h0, mode_w(0, 1, 0, 0, 0));
    bus_wr(4'h4, ctrl_w(0, 2));
    bus_wr(4'h0, mode_w(1, 1, 0, 0, 0));
    time_to_reset(n); check("R5 code2 divides by 512", n, 1536);
    idle(1100);
    bus_wr(4'h0, mode_w(0, 1, 0, 0, 0));
    bus_wr(4'h4, ctrl_w(0, 3));
    bus_wr(4'h0, mode_w(1, 1, 0, 0, 0));
    time_to_reset(n); check("R5 code3 divides by 4096", n, 12288);
    idle(8300);

    // R11 outputs disabled
    bus_wr(4'h0, mode_w(0, 0, 0, 7, 3));
    bus_wr(4'h4, ctrl_w(0, 0));
    bus_wr(4'h0, mode_w(1, 0, 0, 7, 3));
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      if (rst_o || irq_o) seen = 1;
      @(negedge clk);
    end
    check("R11 no pulses", 32'(seen), 32'h0);
    bus_rd(4'hC, d); check("R11 status still set", d, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule